// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter with Alarm

This block holds a wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A single-cycle pulse on the one-second tick input advances the count by one second. Every carry, from seconds up to the year, settles within that one clock cycle. A mode input picks binary or BCD coding for all bytes. A second mode input picks 24-hour coding or 12-hour coding with a PM flag. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn.

The block keeps two copies of the time. The running copy counts on every tick. The user copy drives the outputs and follows the running copy after each tick. While the freeze input is high, the user copy holds still and takes byte writes. The running copy keeps counting during that time. When freeze drops, the running copy is reloaded from the user copy. Three alarm bytes are compared against the new time after every tick. An alarm byte whose two top bits are both set matches any value. The block gives a one-cycle update pulse after every tick and an alarm pulse when all three alarm fields match.

Top module: `cal_keeper`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00 and all three alarm bytes 00, with both pulses low.
- R2: With `bin_mode_i` = 1 every byte is plain binary. With `bin_mode_i` = 0 every byte is BCD, tens digit in bits 7:4 and units in bits 3:0. Seconds 09 advance to 0x0A in binary and to 0x10 in BCD.
- R3: Seconds and minutes wrap from 59 to 0 and carry upward. In 24-hour mode (`h24_mode_i` = 1) hours run 0 to 23, and 23:59:59 becomes 00:00:00 and advances the day.
- R4: In 12-hour mode (`h24_mode_i` = 0) bit 7 of the hours byte means PM and bits 6:0 hold 1 to 12. In BCD, 11:59:59 AM becomes 0x92, 12:59:59 PM becomes 0x81, and 11:59:59 PM (0x91) becomes 0x12 and advances the day.
- R5: On a day change the day of week steps 1..7 and then back to 1. The date wraps to 1 after the month length: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 it is 29 when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R6: While `freeze_i` = 1 the output time bytes hold except for the bytes that are written. The running copy still counts every tick, and the alarm compares against that running copy.
- R7: Writes (`wr_en_i` = 1) go in only while `freeze_i` = 1. The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. Writes to other addresses, and any write while `freeze_i` = 0, change nothing.
- R8: In the first cycle with `freeze_i` low after it was high, the running copy is reloaded from the user copy. A tick in that same cycle advances from the user copy's value.
- R9: `upd_pulse_o` is high for exactly the one cycle after each tick, alongside the updated time.
- R10: `alarm_pulse_o` is high in the same cycle as the update pulse when the new seconds, minutes and hours bytes each equal their alarm byte. An alarm byte with bits 7:6 = 11 matches any value.
- R11: With `dst_en_i` = 1, a tick at 01:59:59 on a Sunday (day of week 1) with month 4 and date 1 to 7 gives 03:00:00 on the same date.
- R12: With `dst_en_i` = 1, on a Sunday with month 10 and date 25 or later, the first tick from 01:59:59 gives 01:00:00. The next time 01:59:59 is reached, the tick gives 02:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| bin_mode_i | input | 1 | 1 = binary coding, 0 = BCD coding |
| h24_mode_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit |
| dst_en_i | input | 1 | Enables the daylight-saving jumps |
| freeze_i | input | 1 | Holds the user copy and opens it to writes |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| sec_o | output | 8 | Seconds, user copy |
| min_o | output | 8 | Minutes, user copy |
| hour_o | output | 8 | Hours, user copy |
| dow_o | output | 8 | Day of week, user copy |
| date_o | output | 8 | Day of month, user copy |
| month_o | output | 8 | Month, user copy |
| year_o | output | 8 | Year, user copy |
| alm_sec_o | output | 8 | Seconds alarm byte |
| alm_min_o | output | 8 | Minutes alarm byte |
| alm_hour_o | output | 8 | Hours alarm byte |
| upd_pulse_o | output | 1 | One-cycle pulse after each tick |
| alarm_pulse_o | output | 1 | One-cycle alarm match pulse |

## Verification
Two functions can act in the same cycle. The freeze release, which reloads the running copy, can coincide with a tick. The update pulse can coincide with the alarm pulse. The bench covers the first case by writing a byte while frozen and then dropping freeze in the same cycle it raises the tick. It then requires the outputs to show the written value plus one second. For the second case the bench freezes the outputs and ticks until the hidden running copy meets the alarm. It then requires both pulses together while the visible seconds byte stays unchanged. Random times and alarm bytes biased toward rollover points also make the two pulses coincide.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int VAL_W     = 7;
  localparam int HOUR_W    = 5;
  localparam int N_ALM     = 3;
  localparam int ADR_SEC   = 0;
  localparam int ADR_MIN   = 1;
  localparam int ADR_HOUR  = 2;
  localparam int ADR_DOW   = 3;
  localparam int ADR_DATE  = 4;
  localparam int ADR_MONTH = 5;
  localparam int ADR_YEAR  = 6;
  localparam int ADR_ALM   = 8;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [HOUR_W-1:0] hr_t;

  typedef struct packed {
    byte_t year;
    byte_t month;
    byte_t date;
    byte_t dow;
    byte_t hour;
    byte_t min;
    byte_t sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                 dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  // byte -> plain number, per coding mode
  function automatic val_t field_dec(input byte_t v, input logic bin);
    val_t hi;
    val_t lo;
    hi = {3'b000, v[7:4]};
    lo = {3'b000, v[3:0]};
    if (bin) return v[6:0];
    return (hi << 3) + (hi << 1) + lo;
  endfunction

  // plain number -> byte, per coding mode
  function automatic byte_t field_enc(input val_t n, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(n / 7'd10);
    ones = 4'(n % 7'd10);
    if (bin) return {1'b0, n};
    return {tens, ones};
  endfunction

  // hours byte -> 0..23
  function automatic hr_t hour_dec(input byte_t v, input logic bin, input logic h24);
    val_t raw;
    hr_t  h12;
    raw = field_dec({1'b0, v[6:0]}, bin);
    if (h24) return raw[4:0];
    h12 = (raw == 7'd12) ? 5'd0 : raw[4:0];
    return v[7] ? h12 + 5'd12 : h12;
  endfunction

  // 0..23 -> hours byte
  function automatic byte_t hour_enc(input hr_t h, input logic bin, input logic h24);
    hr_t   h12;
    byte_t b;
    if (h24) return field_enc({2'b00, h}, bin);
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    b = field_enc({2'b00, h12}, bin);
    return {(h >= 5'd12), b[6:0]};
  endfunction

  function automatic val_t days_in_month(input val_t mo, input val_t yr);
    case (mo)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_t cur_i,
  input  logic bin_i,
  input  logic h24_i,
  input  logic dst_en_i,
  input  logic back_done_i,
  output cal_t nxt_o,
  output logic back_done_o,
  output logic dst_fwd_o,
  output logic dst_back_o
);
  val_t s, m, dw, dt, mo, yr;
  val_t ns, nm, ndw, ndt, nmo, nyr;
  hr_t  h, nh;
  logic sec_wrap, min_wrap, day_wrap, month_wrap, year_wrap, at_159;

  always_comb begin
    s  = field_dec(cur_i.sec,   bin_i);
    m  = field_dec(cur_i.min,   bin_i);
    dw = field_dec(cur_i.dow,   bin_i);
    dt = field_dec(cur_i.date,  bin_i);
    mo = field_dec(cur_i.month, bin_i);
    yr = field_dec(cur_i.year,  bin_i);
    h  = hour_dec(cur_i.hour, bin_i, h24_i);

    at_159     = (h == 5'd1) && (m == 7'd59) && (s == 7'd59);
    dst_fwd_o  = dst_en_i && (mo == 7'd4) && (dw == 7'd1) && (dt <= 7'd7) && at_159;
    dst_back_o = dst_en_i && (mo == 7'd10) && (dw == 7'd1) && (dt >= 7'd25) &&
                 at_159 && !back_done_i;

    sec_wrap   = (s >= 7'd59);
    min_wrap   = sec_wrap && (m >= 7'd59);
    day_wrap   = min_wrap && (h >= 5'd23);
    month_wrap = day_wrap && (dt >= days_in_month(mo, yr));
    year_wrap  = month_wrap && (mo >= 7'd12);

    ns  = sec_wrap ? 7'd0 : s + 7'd1;
    nm  = sec_wrap ? (min_wrap ? 7'd0 : m + 7'd1) : m;
    nh  = min_wrap ? (day_wrap ? 5'd0 : h + 5'd1) : h;
    if (dst_fwd_o)  nh = 5'd3;
    if (dst_back_o) nh = 5'd1;
    ndw = day_wrap ? ((dw >= 7'd7) ? 7'd1 : dw + 7'd1) : dw;
    ndt = month_wrap ? 7'd1 : (day_wrap ? dt + 7'd1 : dt);
    nmo = year_wrap ? 7'd1 : (month_wrap ? mo + 7'd1 : mo);
    nyr = year_wrap ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;

    back_done_o = dst_back_o | (back_done_i & (nh < 5'd3));

    nxt_o.sec   = field_enc(ns,  bin_i);
    nxt_o.min   = field_enc(nm,  bin_i);
    nxt_o.hour  = hour_enc(nh, bin_i, h24_i);
    nxt_o.dow   = field_enc(ndw, bin_i);
    nxt_o.date  = field_enc(ndt, bin_i);
    nxt_o.month = field_enc(nmo, bin_i);
    nxt_o.year  = field_enc(nyr, bin_i);
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_pkg::*;
#(
  parameter int N_FIELDS = 3
) (
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] time_i,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] alarm_i,
  output logic                            hit_o
);
  logic [N_FIELDS-1:0] f_hit;

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_cmp
    assign f_hit[k] = (alarm_i[k][BYTE_W-1 -: 2] == 2'b11) || (alarm_i[k] == time_i[k]);
  end

  assign hit_o = &f_hit;
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bin_mode_i,
  input  logic              h24_mode_i,
  input  logic              dst_en_i,
  input  logic              freeze_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dow_o,
  output logic [7:0]        date_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o,
  output logic [7:0]        alm_sec_o,
  output logic [7:0]        alm_min_o,
  output logic [7:0]        alm_hour_o,
  output logic              upd_pulse_o,
  output logic              alarm_pulse_o
);
  cal_t run_q, usr_q, adv_src, adv_nxt, usr_wr_val;
  logic [N_ALM-1:0][BYTE_W-1:0] alm_q;
  logic [N_ALM-1:0][BYTE_W-1:0] new_tod;
  logic freeze_q, back_done_q, back_done_nxt, upd_q, alarm_q;
  logic release_w, user_wr_w, alarm_hit_w, dst_fwd_w, dst_back_w;
  int   wr_idx;

  assign release_w = freeze_q & ~freeze_i;
  assign user_wr_w = freeze_i & wr_en_i;
  assign adv_src   = release_w ? usr_q : run_q;
  assign wr_idx    = int'(wr_addr_i);

  cal_advance u_adv (
    .cur_i       (adv_src),
    .bin_i       (bin_mode_i),
    .h24_i       (h24_mode_i),
    .dst_en_i    (dst_en_i),
    .back_done_i (back_done_q),
    .nxt_o       (adv_nxt),
    .back_done_o (back_done_nxt),
    .dst_fwd_o   (dst_fwd_w),
    .dst_back_o  (dst_back_w)
  );

  assign new_tod = {adv_nxt.hour, adv_nxt.min, adv_nxt.sec};

  cal_alarm_match #(.N_FIELDS(N_ALM)) u_alm (
    .time_i  (new_tod),
    .alarm_i (alm_q),
    .hit_o   (alarm_hit_w)
  );

  // byte write into the frozen user copy
  always_comb begin
    usr_wr_val = usr_q;
    case (wr_idx)
      ADR_SEC:   usr_wr_val.sec   = wr_data_i;
      ADR_MIN:   usr_wr_val.min   = wr_data_i;
      ADR_HOUR:  usr_wr_val.hour  = wr_data_i;
      ADR_DOW:   usr_wr_val.dow   = wr_data_i;
      ADR_DATE:  usr_wr_val.date  = wr_data_i;
      ADR_MONTH: usr_wr_val.month = wr_data_i;
      ADR_YEAR:  usr_wr_val.year  = wr_data_i;
      default:   usr_wr_val = usr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= CAL_RESET;
      back_done_q <= 1'b0;
    end else if (tick_i) begin
      run_q       <= adv_nxt;
      back_done_q <= back_done_nxt;
    end else if (release_w) begin
      run_q       <= usr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  usr_q <= CAL_RESET;
    else if (tick_i && !freeze_i) usr_q <= adv_nxt;
    else if (user_wr_w)          usr_q <= usr_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
    end else begin
      for (int k = 0; k < N_ALM; k++) begin
        if (user_wr_w && (wr_idx == ADR_ALM + k)) alm_q[k] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      upd_q    <= 1'b0;
      alarm_q  <= 1'b0;
    end else begin
      freeze_q <= freeze_i;
      upd_q    <= tick_i;
      alarm_q  <= tick_i & alarm_hit_w;
    end
  end

  assign sec_o         = usr_q.sec;
  assign min_o         = usr_q.min;
  assign hour_o        = usr_q.hour;
  assign dow_o         = usr_q.dow;
  assign date_o        = usr_q.date;
  assign month_o       = usr_q.month;
  assign year_o        = usr_q.year;
  assign alm_sec_o     = alm_q[0];
  assign alm_min_o     = alm_q[1];
  assign alm_hour_o    = alm_q[2];
  assign upd_pulse_o   = upd_q;
  assign alarm_pulse_o = alarm_q;

  // R2: binary seconds below 59 step by exactly one
  assert_bin_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !release_w && bin_mode_i && run_q.sec < 8'd59)
      |=> (run_q.sec == $past(run_q.sec) + 8'd1));

  // R6: frozen copy without writes holds
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !wr_en_i) |=> $stable(usr_q));

  // R7: unfrozen copy only moves on a tick
  assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && !tick_i) |=> $stable(usr_q));

  // R8: release without a tick copies user values into the running copy
  assert_release_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_w && !tick_i) |=> (run_q == $past(usr_q)));

  // R10: alarm pulse only alongside the update pulse
  assert_alarm_with_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse_o |-> upd_pulse_o);

  // R11: forward jump lands on a whole hour
  assert_dst_fwd_whole_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && dst_fwd_w) |=> (run_q.min == 8'h00 && run_q.sec == 8'h00));

  // R12: backward jump keeps the hour byte and zeroes minutes and seconds
  assert_dst_back_repeat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && dst_back_w && !release_w)
      |=> (run_q.sec == 8'h00 && run_q.min == 8'h00 && run_q.hour == $past(run_q.hour)));
endmodule

// File: tb/cal_keeper_tb.sv
module cal_keeper_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bin_m = 1'b0, h24_m = 1'b1, dst = 1'b0, frz = 1'b0, we = 1'b0;
  logic [3:0] wa = '0;
  logic [7:0] wd = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [7:0] asec_o, amin_o, ahour_o;
  logic upd, alm;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_keeper u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bin_mode_i(bin_m), .h24_mode_i(h24_m),
    .dst_en_i(dst), .freeze_i(frz), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .alm_sec_o(asec_o), .alm_min_o(amin_o),
    .alm_hour_o(ahour_o), .upd_pulse_o(upd), .alarm_pulse_o(alm)
  );

  typedef struct { int s, m, h, dw, dt, mo, yr; } tm_t;
  tm_t m_run, m_usr;
  logic [7:0] a_sec = 8'h00, a_min = 8'h00, a_hr = 8'h00;
  bit m_bd = 0;

  function automatic logic [7:0] enc(int v);
    return bin_m ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] enc_h(int h);
    int k;
    if (h24_m) return enc(h);
    k = h % 12;
    if (k == 0) k = 12;
    return ((h >= 12) ? 8'h80 : 8'h00) | enc(k);
  endfunction

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit amatch(logic [7:0] t, logic [7:0] a);
    return (a >= 8'hC0) || (a == t);
  endfunction

  // one second forward, counted as seconds of the day
  function automatic tm_t step(tm_t t);
    tm_t r;
    int tod;
    r = t;
    tod = t.h * 3600 + t.m * 60 + t.s;
    if (dst && t.mo == 4 && t.dw == 1 && t.dt <= 7 && tod == 7199) tod = 10800;
    else if (dst && t.mo == 10 && t.dw == 1 && t.dt >= 25 && tod == 7199 && !m_bd) begin
      tod = 3600;
      m_bd = 1;
    end else tod = tod + 1;
    if (tod >= 10800) m_bd = 0;
    if (tod == 86400) begin
      tod = 0;
      r.dw = (t.dw == 7) ? 1 : t.dw + 1;
      if (t.dt == mlen(t.mo, t.yr)) begin
        r.dt = 1;
        if (t.mo == 12) begin r.mo = 1; r.yr = (t.yr + 1) % 100; end
        else r.mo = t.mo + 1;
      end else r.dt = t.dt + 1;
    end
    r.h = tod / 3600;
    r.m = (tod / 60) % 60;
    r.s = tod % 60;
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_user(string tag);
    chk({tag, " sec"},   sec_o,   enc(m_usr.s));
    chk({tag, " min"},   min_o,   enc(m_usr.m));
    chk({tag, " hour"},  hour_o,  enc_h(m_usr.h));
    chk({tag, " dow"},   dow_o,   enc(m_usr.dw));
    chk({tag, " date"},  date_o,  enc(m_usr.dt));
    chk({tag, " month"}, month_o, enc(m_usr.mo));
    chk({tag, " year"},  year_o,  enc(m_usr.yr));
  endtask

  task automatic wr(int a, logic [7:0] d);
    wa = 4'(a); wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic load(int s, int m, int h, int dw, int dt, int mo, int yr);
    tm_t t;
    t.s = s; t.m = m; t.h = h; t.dw = dw; t.dt = dt; t.mo = mo; t.yr = yr;
    frz = 1'b1;
    wr(0, enc(s)); wr(1, enc(m)); wr(2, enc_h(h)); wr(3, enc(dw));
    wr(4, enc(dt)); wr(5, enc(mo)); wr(6, enc(yr));
    frz = 1'b0;
    @(negedge clk);
    m_usr = t; m_run = t;
  endtask

  task automatic set_alarm(logic [7:0] a0, logic [7:0] a1, logic [7:0] a2);
    frz = 1'b1;
    wr(8, a0); wr(9, a1); wr(10, a2);
    frz = 1'b0;
    @(negedge clk);
    a_sec = a0; a_min = a1; a_hr = a2;
    m_run = m_usr;
  endtask

  task automatic tick1(string tag);
    bit ea;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    m_run = step(m_run);
    if (!frz) m_usr = m_run;
    ea = amatch(enc(m_run.s), a_sec) && amatch(enc(m_run.m), a_min) && amatch(enc_h(m_run.h), a_hr);
    chk_user(tag);
    chk({tag, " R9 upd"}, {7'b0, upd}, 8'h01);
    chk({tag, " R10 alarm"}, {7'b0, alm}, {7'b0, ea});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00); chk("R1 dow", dow_o, 8'h01);
    chk("R1 date", date_o, 8'h01); chk("R1 month", month_o, 8'h01);
    chk("R1 year", year_o, 8'h00); chk("R1 alarms", asec_o | amin_o | ahour_o, 8'h00);
    chk("R1 pulses", {6'b0, upd, alm}, 8'h00);
    m_usr = '{0, 0, 0, 1, 1, 1, 0}; m_run = m_usr;

    // R2 coding
    set_alarm(8'h3F, 8'h3F, 8'h3F);
    load(9, 0, 0, 3, 5, 6, 10); tick1("R2 bcd");
    chk("R2 bcd carry", sec_o, 8'h10);
    @(negedge clk);
    chk("R9 single cycle", {7'b0, upd}, 8'h00);
    bin_m = 1'b1;
    load(9, 0, 0, 3, 5, 6, 10); tick1("R2 bin");
    chk("R2 bin step", sec_o, 8'h0A);
    bin_m = 1'b0;

    // R3 rollover
    load(59, 59, 23, 2, 14, 7, 21); tick1("R3 midnight");
    chk("R3 hour zero", hour_o, 8'h00); chk("R3 date step", date_o, 8'h15);

    // R4 12-hour
    h24_m = 1'b0;
    load(59, 59, 11, 2, 3, 3, 21); tick1("R4 noon");
    chk("R4 noon byte", hour_o, 8'h92);
    load(59, 59, 12, 2, 3, 3, 21); tick1("R4 one pm");
    chk("R4 one pm byte", hour_o, 8'h81);
    load(59, 59, 23, 2, 3, 3, 21); tick1("R4 midnight");
    chk("R4 midnight byte", hour_o, 8'h12); chk("R4 day step", date_o, 8'h04);
    bin_m = 1'b1;
    load(59, 59, 11, 2, 3, 3, 21); tick1("R4 bin noon");
    chk("R4 bin noon byte", hour_o, 8'h8C);
    bin_m = 1'b0; h24_m = 1'b1;

    // R5 calendar
    load(59, 59, 23, 7, 28, 2, 24); tick1("R5 leap feb");
    chk("R5 leap date", date_o, 8'h29); chk("R5 dow wrap", dow_o, 8'h01);
    load(59, 59, 23, 4, 28, 2, 23); tick1("R5 feb");
    chk("R5 march", month_o, 8'h03); chk("R5 first", date_o, 8'h01);
    load(59, 59, 23, 4, 30, 4, 23); tick1("R5 short month");
    chk("R5 may", month_o, 8'h05);
    load(59, 59, 23, 5, 31, 12, 99); tick1("R5 century");
    chk("R5 year wrap", year_o, 8'h00); chk("R5 jan", month_o, 8'h01);

    // R6 and R10: frozen outputs, alarm from running copy
    load(0, 0, 10, 2, 9, 9, 22);
    set_alarm(8'h03, 8'hC0, 8'hC5);
    frz = 1'b1;
    tick1("R6 frozen 1"); tick1("R6 frozen 2"); tick1("R6 R10 frozen 3");
    chk("R10 alarm on hidden time", {7'b0, alm}, 8'h01);
    chk("R6 sec held", sec_o, 8'h00);
    frz = 1'b0;
    @(negedge clk);
    m_run = m_usr;
    tick1("R8 release reload");
    chk("R8 sec from user", sec_o, 8'h01);

    // R7 ignored writes
    wr(0, 8'h45);
    chk_user("R7 unfrozen write");
    frz = 1'b1;
    wr(7, 8'h55); wr(15, 8'h66);
    chk_user("R7 unused address");
    chk("R7 alarm sec kept", asec_o, 8'h03);
    chk("R7 alarm hour kept", ahour_o, 8'hC5);
    frz = 1'b0;
    @(negedge clk);

    // R8 release and tick in one cycle
    frz = 1'b1;
    wr(0, 8'h30);
    frz = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    m_usr.s = 30; m_run = step(m_usr); m_usr = m_run;
    chk_user("R8 release with tick");
    chk("R8 sec 31", sec_o, 8'h31);

    // R11 spring forward
    dst = 1'b1;
    set_alarm(8'h3F, 8'h3F, 8'h3F);
    load(59, 59, 1, 1, 5, 4, 25); tick1("R11 forward");
    chk("R11 hour three", hour_o, 8'h03);
    dst = 1'b0;
    load(59, 59, 1, 1, 5, 4, 25); tick1("R11 disabled");
    chk("R11 hour two", hour_o, 8'h02);

    // R12 fall back once
    dst = 1'b1;
    load(59, 59, 1, 1, 27, 10, 24); tick1("R12 back");
    chk("R12 hour one", hour_o, 8'h01); chk("R12 min zero", min_o, 8'h00);
    for (int i = 0; i < 3599; i++) tick1("R12 repeat hour");
    tick1("R12 second pass");
    chk("R12 hour two", hour_o, 8'h02);
    dst = 1'b0;

    // random mix biased to rollover points
    for (int i = 0; i < 250; i++) begin
      int s, m, h, dw, dt, mo, yr, n;
      logic [7:0] a0, a1, a2;
      bin_m = 1'($urandom % 2);
      h24_m = 1'($urandom % 2);
      dst   = 1'($urandom % 2);
      mo = 1 + $urandom % 12;
      yr = $urandom % 100;
      dt = ($urandom % 3 == 0) ? mlen(mo, yr) : 1 + $urandom % mlen(mo, yr);
      h  = ($urandom % 3 == 0) ? 23 : $urandom % 24;
      m  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      s  = ($urandom % 2 == 0) ? 58 + $urandom % 2 : $urandom % 60;
      dw = 1 + $urandom % 7;
      a0 = ($urandom % 2 == 0) ? 8'hC0 | 8'($urandom % 64) : enc((s + 1) % 60);
      a1 = ($urandom % 2 == 0) ? 8'hC0 | 8'($urandom % 64) : enc(($urandom % 2 == 0) ? m : 0);
      a2 = ($urandom % 2 == 0) ? 8'hFF : enc_h(($urandom % 2 == 0) ? h : (h + 1) % 24);
      set_alarm(a0, a1, a2);
      load(s, m, h, dw, dt, mo, yr);
      n = 1 + $urandom % 4;
      for (int j = 0; j < n; j++) tick1("R2 R3 R4 R5 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule